// File: doc/BRIEF.md
# Power-Mode and Context-Retention Controller

This block sequences the low-power behaviour of a small microcontroller whose logic is split into eleven independently switchable power domains. Software can copy the processor context into nonvolatile shadow flip-flops (SAVE) or bring it back (LOAD) at any time while running. It can also ask for one of three low-power modes. In standby only the main clock stops. In power-gating mode the domains that software has not marked as needed are isolated and switched off. In sleep mode every domain is switched off and the core DC/DC converter is also disabled.

Before any domain loses power the controller requests a context backup and waits for its acknowledge. It then clamps the outputs of the affected domains and opens their switches. On a wakeup event it reverses the steps. The converter comes back first when needed, then every switch closes. The controller waits for supply-good on all domains and requests a context restore, then releases isolation. The processor therefore resumes from the restored context and no boot code has to run. The shadow cells, the analog switches and the converter sit outside the block and answer through acknowledge and ready inputs.

The sequencer states are RUN, SAVE, LOAD, STBY, DN_BKP, DN_ISO, DN_SW, LP, UP_DCDC, UP_SW, UP_RST and UP_ISO. Their transitions are:
- RUN→SAVE on a save request.
- RUN→LOAD on a load request while a context is held.
- RUN→STBY on a standby request.
- RUN→DN_BKP on a power-gating or sleep request.
- SAVE→RUN and LOAD→RUN on the matching acknowledge.
- STBY→RUN on a wakeup.
- DN_BKP→DN_ISO on the backup acknowledge.
- DN_ISO→DN_SW and DN_SW→LP unconditionally.
- LP→UP_DCDC (sleep) or LP→UP_SW (power gating) on a wakeup, either live or latched.
- UP_DCDC→UP_SW on converter-ready.
- UP_SW→UP_RST once every domain reports supply-good.
- UP_RST→UP_ISO on the restore acknowledge.
- UP_ISO→RUN unconditionally.

Top module: `nvpm_ctrl`

## Requirements
- R1: After reset every domain switch is closed, no isolation is active, the clock runs, the converter is enabled, no backup or restore request is raised, the error flag is clear and the reported mode is 0 (run).
- R2: A save request in run mode raises the backup request until the backup acknowledge arrives, without gating the clock or touching any domain, and marks the saved context valid.
- R3: A load request while a valid context exists raises the restore request until the restore acknowledge, and clears the error flag.
- R4: A load request while no valid context exists raises no restore request and sets the error flag one cycle later; the flag stays set until a load is accepted.
- R5: A mode request with code 1 (standby) gates the clock one cycle later, keeps every domain switched on, raises no backup, and reports mode 1; a wakeup releases the clock and returns to mode 0 without any restore request.
- R6: A mode request with code 2 (power gating) raises a backup request first. After its acknowledge, isolation is set on the domains whose keep bit is 0, and their switches open one cycle later. Domains with keep bit 1 stay on, and the reported mode is 2.
- R7: A mode request with code 3 (sleep) takes every domain down in the same order as R6 and then drives the converter enable low. The reported mode is 3.
- R8: A wakeup from power gating or sleep closes all switches and waits for supply-good on all domains. It then issues exactly one restore request, releases isolation and returns to mode 0 with the clock running.
- R9: On wakeup from sleep the converter enable rises first, and no domain switch closes while converter-ready is low.
- R10: A wakeup event arriving during the power-down steps is held and serviced as soon as the stable low-power state is reached.
- R11: Mode code 0 is ignored. Simultaneous requests are served in the order save, load, mode. Save, load and mode requests outside run mode are ignored.
- R12: A domain whose switch is open always has its isolation asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on controller clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| save_req | input | 1 | Software context-save pulse |
| load_req | input | 1 | Software context-load pulse |
| mode_vld | input | 1 | Mode request strobe |
| mode_sel | input | 2 | Requested mode: 1 standby, 2 power gating, 3 sleep, 0 none |
| dom_keep | input | 11 | Domains that stay powered in power-gating mode |
| wake_evt | input | 1 | Wakeup event |
| bkp_ack | input | 1 | Backup done from the shadow cells |
| rst_ack | input | 1 | Restore done from the shadow cells |
| pwr_good | input | 11 | Per-domain supply good |
| dcdc_ready | input | 1 | Converter output ready |
| dom_sw_en | output | 11 | Power switch closed, per domain |
| dom_iso_en | output | 11 | Output clamp active, per domain |
| clk_gate | output | 1 | Main clock stopped |
| dcdc_en | output | 1 | Converter enable |
| bkp_req | output | 1 | Backup request, held until acknowledge |
| rst_req | output | 1 | Restore request, held until acknowledge |
| load_err | output | 1 | Load refused for lack of saved context |
| status_mode | output | 2 | Current mode code |
| status_dom_on | output | 11 | Domains switched on with supply good |

## Verification
The hardest situation to reach is a wakeup that lands in the middle of the power-down steps (R10). It has to arrive after the mode request is accepted but before the switches open. The bench delays the backup acknowledge by several cycles and pulses the wakeup while the backup request is visibly held, then confirms that the domains still went down and came back with one restore. It sweeps many keep patterns through full power-gating cycles, including every single-domain and every all-but-one pattern, and computes the expected switch and isolation vectors from each pattern.

// File: rtl/nvpm_pkg.sv
package nvpm_pkg;

    typedef enum logic [1:0] {
        PM_RUN   = 2'd0,
        PM_STBY  = 2'd1,
        PM_PGATE = 2'd2,
        PM_SLEEP = 2'd3
    } pm_mode_e;

    typedef enum logic [3:0] {
        ST_RUN     = 4'd0,
        ST_SAVE    = 4'd1,
        ST_LOAD    = 4'd2,
        ST_STBY    = 4'd3,
        ST_DN_BKP  = 4'd4,
        ST_DN_ISO  = 4'd5,
        ST_DN_SW   = 4'd6,
        ST_LP      = 4'd7,
        ST_UP_DCDC = 4'd8,
        ST_UP_SW   = 4'd9,
        ST_UP_RST  = 4'd10,
        ST_UP_ISO  = 4'd11
    } seq_state_e;

    typedef struct packed {
        logic iso_on;
        logic sw_off;
        logic sw_on;
        logic iso_off;
    } dom_cmd_t;

endpackage

// File: rtl/nvpm_dom_slice.sv
module nvpm_dom_slice
    import nvpm_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  dom_cmd_t cmd,
    input  logic     sel,
    output logic     sw_en,
    output logic     iso_en
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            iso_en <= 1'b0;
        end else if (cmd.iso_on && sel) begin
            iso_en <= 1'b1;
        end else if (cmd.iso_off) begin
            iso_en <= 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sw_en <= 1'b1;
        end else if (cmd.sw_off && sel && iso_en) begin
            sw_en <= 1'b0;
        end else if (cmd.sw_on) begin
            sw_en <= 1'b1;
        end
    end

endmodule

// File: rtl/nvpm_ctx_track.sv
module nvpm_ctx_track (
    input  logic clk,
    input  logic rst_n,
    input  logic bkp_done,
    input  logic load_accept,
    input  logic load_reject,
    output logic ctx_valid,
    output logic load_err
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctx_valid <= 1'b0;
        end else if (bkp_done) begin
            ctx_valid <= 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            load_err <= 1'b0;
        end else if (load_reject) begin
            load_err <= 1'b1;
        end else if (load_accept) begin
            load_err <= 1'b0;
        end
    end

endmodule

// File: rtl/nvpm_fsm.sv
module nvpm_fsm
    import nvpm_pkg::*;
#(
    parameter int ND = 11
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          save_req,
    input  logic          load_req,
    input  logic          mode_vld,
    input  logic [1:0]    mode_sel,
    input  logic [ND-1:0] dom_keep,
    input  logic          wake_evt,
    input  logic          bkp_ack,
    input  logic          rst_ack,
    input  logic          all_pwr_good,
    input  logic          dcdc_ready,
    input  logic          ctx_valid,
    output seq_state_e    state_o,
    output pm_mode_e      mode_o,
    output logic [ND-1:0] down_mask,
    output dom_cmd_t      dom_cmd,
    output logic          clk_gate,
    output logic          dcdc_en,
    output logic          bkp_req,
    output logic          rst_req,
    output logic          bkp_done,
    output logic          load_accept,
    output logic          load_reject
);

    seq_state_e    state_q, state_d;
    pm_mode_e      mode_q, mode_d;
    logic [ND-1:0] mask_q, mask_d;
    logic          wake_pend_q;
    logic          wake_any;
    logic          in_down;

    assign wake_any = wake_evt || wake_pend_q;
    assign in_down  = (state_q == ST_DN_BKP) || (state_q == ST_DN_ISO) || (state_q == ST_DN_SW);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q     <= ST_RUN;
            mode_q      <= PM_RUN;
            mask_q      <= '0;
            wake_pend_q <= 1'b0;
        end else begin
            state_q <= state_d;
            mode_q  <= mode_d;
            mask_q  <= mask_d;
            if (in_down && wake_evt) begin
                wake_pend_q <= 1'b1;
            end else if ((state_q == ST_LP) || (state_q == ST_STBY) || (state_q == ST_RUN)) begin
                wake_pend_q <= 1'b0;
            end
        end
    end

    // next state
    always_comb begin
        state_d     = state_q;
        mode_d      = mode_q;
        mask_d      = mask_q;
        bkp_done    = 1'b0;
        load_accept = 1'b0;
        load_reject = 1'b0;
        unique case (state_q)
            ST_RUN: begin
                if (save_req) begin
                    state_d = ST_SAVE;
                end else if (load_req) begin
                    if (ctx_valid) begin
                        state_d     = ST_LOAD;
                        load_accept = 1'b1;
                    end else begin
                        load_reject = 1'b1;
                    end
                end else if (mode_vld) begin
                    unique case (pm_mode_e'(mode_sel))
                        PM_RUN: begin
                        end
                        PM_STBY: begin
                            state_d = ST_STBY;
                            mode_d  = PM_STBY;
                        end
                        PM_PGATE: begin
                            state_d = ST_DN_BKP;
                            mode_d  = PM_PGATE;
                            mask_d  = ~dom_keep;
                        end
                        PM_SLEEP: begin
                            state_d = ST_DN_BKP;
                            mode_d  = PM_SLEEP;
                            mask_d  = '1;
                        end
                    endcase
                end
            end
            ST_SAVE: begin
                if (bkp_ack) begin
                    state_d  = ST_RUN;
                    bkp_done = 1'b1;
                end
            end
            ST_LOAD: begin
                if (rst_ack) begin
                    state_d = ST_RUN;
                end
            end
            ST_STBY: begin
                if (wake_any) begin
                    state_d = ST_RUN;
                    mode_d  = PM_RUN;
                end
            end
            ST_DN_BKP: begin
                if (bkp_ack) begin
                    state_d  = ST_DN_ISO;
                    bkp_done = 1'b1;
                end
            end
            ST_DN_ISO: state_d = ST_DN_SW;
            ST_DN_SW:  state_d = ST_LP;
            ST_LP: begin
                if (wake_any) begin
                    state_d = (mode_q == PM_SLEEP) ? ST_UP_DCDC : ST_UP_SW;
                end
            end
            ST_UP_DCDC: begin
                if (dcdc_ready) begin
                    state_d = ST_UP_SW;
                end
            end
            ST_UP_SW: begin
                if (all_pwr_good) begin
                    state_d = ST_UP_RST;
                end
            end
            ST_UP_RST: begin
                if (rst_ack) begin
                    state_d = ST_UP_ISO;
                end
            end
            ST_UP_ISO: begin
                state_d = ST_RUN;
                mode_d  = PM_RUN;
            end
            default: state_d = ST_RUN;
        endcase
    end

    // outputs
    always_comb begin
        clk_gate        = !((state_q == ST_RUN) || (state_q == ST_SAVE) || (state_q == ST_LOAD));
        bkp_req         = (state_q == ST_SAVE) || (state_q == ST_DN_BKP);
        rst_req         = (state_q == ST_LOAD) || (state_q == ST_UP_RST);
        dcdc_en         = !((state_q == ST_LP) && (mode_q == PM_SLEEP));
        dom_cmd.iso_on  = (state_q == ST_DN_ISO);
        dom_cmd.sw_off  = (state_q == ST_DN_SW);
        dom_cmd.sw_on   = (state_q == ST_UP_SW);
        dom_cmd.iso_off = (state_q == ST_UP_ISO);
    end

    assign state_o   = state_q;
    assign mode_o    = mode_q;
    assign down_mask = mask_q;

endmodule

// File: rtl/nvpm_ctrl.sv
module nvpm_ctrl
    import nvpm_pkg::*;
#(
    parameter int ND = 11
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          save_req,
    input  logic          load_req,
    input  logic          mode_vld,
    input  logic [1:0]    mode_sel,
    input  logic [ND-1:0] dom_keep,
    input  logic          wake_evt,
    input  logic          bkp_ack,
    input  logic          rst_ack,
    input  logic [ND-1:0] pwr_good,
    input  logic          dcdc_ready,
    output logic [ND-1:0] dom_sw_en,
    output logic [ND-1:0] dom_iso_en,
    output logic          clk_gate,
    output logic          dcdc_en,
    output logic          bkp_req,
    output logic          rst_req,
    output logic          load_err,
    output logic [1:0]    status_mode,
    output logic [ND-1:0] status_dom_on
);

    seq_state_e    seq_state;
    pm_mode_e      cur_mode;
    logic [ND-1:0] down_mask;
    dom_cmd_t      dom_cmd;
    logic          ctx_valid;
    logic          bkp_done;
    logic          load_accept;
    logic          load_reject;

    nvpm_fsm #(.ND(ND)) fsm_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .save_req    (save_req),
        .load_req    (load_req),
        .mode_vld    (mode_vld),
        .mode_sel    (mode_sel),
        .dom_keep    (dom_keep),
        .wake_evt    (wake_evt),
        .bkp_ack     (bkp_ack),
        .rst_ack     (rst_ack),
        .all_pwr_good(&pwr_good),
        .dcdc_ready  (dcdc_ready),
        .ctx_valid   (ctx_valid),
        .state_o     (seq_state),
        .mode_o      (cur_mode),
        .down_mask   (down_mask),
        .dom_cmd     (dom_cmd),
        .clk_gate    (clk_gate),
        .dcdc_en     (dcdc_en),
        .bkp_req     (bkp_req),
        .rst_req     (rst_req),
        .bkp_done    (bkp_done),
        .load_accept (load_accept),
        .load_reject (load_reject)
    );

    nvpm_ctx_track ctx_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .bkp_done   (bkp_done),
        .load_accept(load_accept),
        .load_reject(load_reject),
        .ctx_valid  (ctx_valid),
        .load_err   (load_err)
    );

    for (genvar g = 0; g < ND; g++) begin : g_dom
        nvpm_dom_slice slice_i (
            .clk   (clk),
            .rst_n (rst_n),
            .cmd   (dom_cmd),
            .sel   (down_mask[g]),
            .sw_en (dom_sw_en[g]),
            .iso_en(dom_iso_en[g])
        );
    end

    assign status_mode   = cur_mode;
    assign status_dom_on = dom_sw_en & pwr_good;

endmodule

// File: rtl/nvpm_ctrl_chk.sv
module nvpm_ctrl_chk
    import nvpm_pkg::*;
#(
    parameter int ND = 11
) (
    input logic          clk,
    input logic          rst_n,
    input logic          save_req,
    input logic          load_req,
    input logic [ND-1:0] dom_sw_en,
    input logic [ND-1:0] dom_iso_en,
    input logic          clk_gate,
    input logic          dcdc_en,
    input logic          rst_req,
    input logic          load_err,
    input logic [1:0]    status_mode,
    input logic          ctx_valid,
    input logic [3:0]    seq_state
);

    AST_OFF_ISOLATED: assert property (@(posedge clk) disable iff (!rst_n)
        (~dom_sw_en & ~dom_iso_en) == '0); // R12

    AST_STBY_ALL_ON: assert property (@(posedge clk) disable iff (!rst_n)
        (status_mode == 2'd1) |-> ((&dom_sw_en) && clk_gate)); // R5

    AST_SLEEP_RAIL_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
        !dcdc_en |-> (dom_sw_en == '0)); // R7

    AST_CLOSE_NEEDS_RAIL: assert property (@(posedge clk) disable iff (!rst_n)
        ((dom_sw_en & ~$past(dom_sw_en)) != '0) |-> dcdc_en); // R9

    AST_LOAD_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
        ((seq_state == ST_RUN) && load_req && !save_req && !ctx_valid) |=> (!rst_req && load_err)); // R4

    AST_ISO_AFTER_SAVE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(|dom_iso_en) |-> ctx_valid); // R6

    AST_RUN_UNGATED: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_state == ST_RUN) |-> !clk_gate); // R8

endmodule

bind nvpm_ctrl nvpm_ctrl_chk #(.ND(ND)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .save_req   (save_req),
    .load_req   (load_req),
    .dom_sw_en  (dom_sw_en),
    .dom_iso_en (dom_iso_en),
    .clk_gate   (clk_gate),
    .dcdc_en    (dcdc_en),
    .rst_req    (rst_req),
    .load_err   (load_err),
    .status_mode(status_mode),
    .ctx_valid  (ctx_valid),
    .seq_state  (seq_state)
);

// File: tb/nvpm_ctrl_tb_top.sv
module nvpm_ctrl_tb_top;

    localparam int ND   = 11;
    localparam int ALAT = 3;
    localparam int PLAT = 3;
    localparam int DLAT = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          save_req = 1'b0, load_req = 1'b0, mode_vld = 1'b0;
    logic [1:0]    mode_sel = 2'd0;
    logic [ND-1:0] dom_keep = '0;
    logic          wake_evt = 1'b0;
    logic          bkp_ack = 1'b0, rst_ack = 1'b0;
    logic [ND-1:0] pwr_good = '1;
    logic          dcdc_ready = 1'b1;
    logic [ND-1:0] dom_sw_en, dom_iso_en, status_dom_on;
    logic          clk_gate, dcdc_en, bkp_req, rst_req, load_err;
    logic [1:0]    status_mode;

    int checks = 0;
    int errors = 0;
    int bkp_rises = 0, rst_rises = 0, rail_viol = 0, down_seen = 0;

    always #4 clk = ~clk;

    nvpm_ctrl #(.ND(ND)) dut_i (.*);

    // acknowledge, supply and converter models, updated away from the active edge
    logic [ND-1:0] pg_pipe [PLAT];
    logic [DLAT-1:0] dc_pipe = '1;
    int bcnt = 0, rcnt = 0;
    logic bkp_prev = 1'b0, rst_prev = 1'b0;
    logic [ND-1:0] sw_prev = '1;
    initial for (int i = 0; i < PLAT; i++) pg_pipe[i] = '1;

    always @(negedge clk) begin
        bkp_ack = 1'b0;
        rst_ack = 1'b0;
        if (bkp_req) begin
            bcnt++;
            if (bcnt == ALAT) begin bkp_ack = 1'b1; bcnt = 0; end
        end else bcnt = 0;
        if (rst_req) begin
            rcnt++;
            if (rcnt == ALAT) begin rst_ack = 1'b1; rcnt = 0; end
        end else rcnt = 0;
        if (bkp_req && !bkp_prev) bkp_rises++;
        if (rst_req && !rst_prev) rst_rises++;
        if (((dom_sw_en & ~sw_prev) != '0) && !dcdc_ready) rail_viol++;
        if (dom_sw_en != '1) down_seen = 1;
        bkp_prev = bkp_req;
        rst_prev = rst_req;
        sw_prev  = dom_sw_en;
        pwr_good = pg_pipe[PLAT-1];
        for (int i = PLAT-1; i > 0; i--) pg_pipe[i] = pg_pipe[i-1];
        pg_pipe[0] = dom_sw_en;
        dcdc_ready = dc_pipe[DLAT-1];
        dc_pipe = {dc_pipe[DLAT-2:0], dcdc_en};
    end

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic pulse_mode(logic [1:0] m);
        mode_sel = m; mode_vld = 1'b1;
        tick(1);
        mode_vld = 1'b0; mode_sel = 2'd0;
    endtask

    task automatic pulse_wake();
        wake_evt = 1'b1;
        tick(1);
        wake_evt = 1'b0;
    endtask

    task automatic gate_cycle(logic [ND-1:0] keep);
        int r0;
        dom_keep = keep;
        r0 = rst_rises;
        pulse_mode(2'd2);
        tick(20);
        chk(dom_sw_en == keep, "R6 switches", dom_sw_en, keep);
        chk(dom_iso_en == ~keep, "R6 isolation", dom_iso_en, ~keep);
        chk(status_mode == 2'd2 && clk_gate && dcdc_en, "R6 mode", status_mode, 2);
        pulse_wake();
        tick(30);
        chk(dom_sw_en == '1 && dom_iso_en == '0, "R8 domains", {dom_sw_en, dom_iso_en}, {{ND{1'b1}}, {ND{1'b0}}});
        chk(status_mode == 2'd0 && !clk_gate, "R8 mode", status_mode, 0);
        chk(rst_rises == r0 + 1, "R8 one restore", rst_rises - r0, 1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int b0, r0;
        tick(3);
        rst_n = 1'b1;
        tick(2);
        // R1 reset state
        chk(dom_sw_en == '1 && dom_iso_en == '0, "R1 domains", {dom_sw_en, dom_iso_en}, {{ND{1'b1}}, {ND{1'b0}}});
        chk(!clk_gate && dcdc_en && !bkp_req && !rst_req && !load_err && status_mode == 0,
            "R1 controls", {clk_gate, dcdc_en, bkp_req, rst_req, load_err, status_mode}, 7'b0100000);

        // R4 load with no context
        load_req = 1'b1; tick(1); load_req = 1'b0;
        chk(load_err && !rst_req, "R4 reject", {load_err, rst_req}, 2'b10);
        tick(5);
        chk(load_err && rst_rises == 0, "R4 sticky", {load_err, 8'(rst_rises)}, 9'h100);

        // R11 mode code 0 ignored
        pulse_mode(2'd0);
        chk(!clk_gate && !bkp_req && status_mode == 0, "R11 code0", {clk_gate, bkp_req, status_mode}, 0);

        // R2 save
        b0 = bkp_rises;
        save_req = 1'b1; tick(1); save_req = 1'b0;
        chk(bkp_req && !clk_gate && dom_sw_en == '1, "R2 request", {bkp_req, clk_gate}, 2'b10);
        tick(6);
        chk(!bkp_req && bkp_rises == b0 + 1, "R2 done", bkp_rises - b0, 1);

        // R3 load accepted
        r0 = rst_rises;
        load_req = 1'b1; tick(1); load_req = 1'b0;
        chk(rst_req && !load_err, "R3 accept", {rst_req, load_err}, 2'b10);
        tick(6);
        chk(!rst_req && rst_rises == r0 + 1, "R3 done", rst_rises - r0, 1);

        // R11 priority: save over load and mode
        save_req = 1'b1; load_req = 1'b1; mode_sel = 2'd1; mode_vld = 1'b1;
        tick(1);
        save_req = 1'b0; load_req = 1'b0; mode_vld = 1'b0; mode_sel = 2'd0;
        chk(bkp_req && !rst_req && status_mode == 0, "R11 priority", {bkp_req, rst_req, status_mode}, 4'b1000);
        tick(6);

        // R5 standby
        b0 = bkp_rises; r0 = rst_rises;
        pulse_mode(2'd1);
        chk(clk_gate && status_mode == 2'd1 && dom_sw_en == '1, "R5 enter", {clk_gate, status_mode}, 3'b101);
        save_req = 1'b1; tick(1); save_req = 1'b0;
        tick(2);
        chk(!bkp_req && bkp_rises == b0, "R11 save ignored in standby", bkp_rises - b0, 0);
        pulse_wake();
        chk(!clk_gate && status_mode == 0, "R5 leave", {clk_gate, status_mode}, 0);
        tick(4);
        chk(rst_rises == r0, "R5 no restore", rst_rises - r0, 0);

        // R6/R8 sweep of keep patterns
        gate_cycle('0);
        gate_cycle('1);
        gate_cycle(11'h555);
        gate_cycle(11'h2AA);
        for (int i = 0; i < ND; i++) gate_cycle(ND'(1) << i);
        for (int i = 0; i < ND; i++) gate_cycle(~(ND'(1) << i));

        // R7/R9 sleep
        r0 = rst_rises;
        rail_viol = 0;
        pulse_mode(2'd3);
        tick(20);
        chk(dom_sw_en == '0 && dom_iso_en == '1, "R7 all down", {dom_sw_en, dom_iso_en}, {{ND{1'b0}}, {ND{1'b1}}});
        chk(!dcdc_en && status_mode == 2'd3, "R7 rail off", {dcdc_en, status_mode}, 3'b011);
        pulse_wake();
        tick(2);
        chk(dcdc_en && dom_sw_en == '0, "R9 rail first", {dcdc_en, dom_sw_en}, {1'b1, {ND{1'b0}}});
        tick(35);
        chk(rail_viol == 0, "R9 no early close", rail_viol, 0);
        chk(dom_sw_en == '1 && dom_iso_en == '0 && status_mode == 0 && rst_rises == r0 + 1,
            "R8 sleep wake", rst_rises - r0, 1);

        // R10 wake during power-down
        r0 = rst_rises;
        down_seen = 0;
        dom_keep = 11'h00F;
        pulse_mode(2'd2);
        chk(bkp_req, "R10 in backup", bkp_req, 1);
        pulse_wake();
        tick(40);
        chk(down_seen == 1, "R10 went down", down_seen, 1);
        chk(status_mode == 0 && dom_sw_en == '1 && dom_iso_en == '0 && rst_rises == r0 + 1,
            "R10 serviced", rst_rises - r0, 1);

        // R12 isolation invariant observed at ports after all sequences
        chk((~dom_sw_en & ~dom_iso_en) == '0, "R12 isolation", dom_iso_en, ~dom_sw_en);

        // R4 flag cleared by accepted load
        load_req = 1'b1; tick(1); load_req = 1'b0;
        chk(!load_err && rst_req, "R4 cleared", {load_err, rst_req}, 2'b01);
        tick(6);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule